// File: doc/BRIEF.md
# GPIO Pin-Change Interrupt Generator

This block watches a port of general-purpose input pins and turns selected transitions on them into interrupt requests. Each pin has a two-bit trigger mode: any change, rising only, or falling only. It also has an enable bit and a sticky event flag. The pins are sampled on the rising clock edge while the clock-enable input is high. A transition is the difference between the two most recent samples, so only levels that are present at a sampling edge can cause an event. Detection uses the raw pin value, so it works the same whether the pin is driven by the port logic or taken over by a peripheral.

The flags record which pins saw a qualifying transition. A flag is set whether or not its pin is enabled. Software clears flags by writing a mask word in which a zero bit clears the matching flag and a one bit leaves it alone. If hardware sets a flag in the same cycle that software clears it, the flag stays set. The pins are grouped in fixed sets of eight. Each group drives one request line, which is high while any pin in the group is both flagged and enabled, so each group can have its own handler.

Configuration goes through a small synchronous write port and a combinational read port that share one 2-bit register address map. The read port returns the current register contents.

Top module: `gpio_chg_irq`

## Requirements
- R1: After a synchronous reset, the enable register, both mode words and the flag register read zero, and all group request lines are low.
- R2: In mode 00 (any change), both a rising and a falling transition of a pin set its flag. The flag is visible after the second rising clock edge that follows the pin change, and not after the first.
- R3: In mode 01 (rising), a 0-to-1 transition sets the flag and a 1-to-0 transition does not.
- R4: In mode 10 (falling), a 1-to-0 transition sets the flag and a 0-to-1 transition does not.
- R5: Mode 11 behaves exactly like mode 00.
- R6: A flag sets on a qualifying transition even when the pin's enable bit is 0. Such a pin raises no request until its enable bit is 1.
- R7: Request line g is high exactly when some pin in 8g..8g+7 is both flagged and enabled.
- R8: A write to address 3 (flags) clears every flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. Without such a write, a set flag stays set.
- R9: If a transition sets a flag in the same cycle that a flag write clears it, the flag ends up set.
- R10: While `clk_en` is low, sampling stops and no flag is set. A level change made during that time is detected once sampling resumes.
- R11: A pulse that starts and ends between two rising clock edges sets no flag. A pulse held across a rising edge sets the flag in any-change mode.
- R12: Register map: address 0 is the enable bits (bit i = pin i). Address 1 holds the modes of pins 0..15 and address 2 those of pins 16..31, with pin i using bits 2(i mod 16)+1 : 2(i mod 16). Written values read back unchanged.
- R13: The first two samples after reset only prime the detector. A pin that is already high when reset is released sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Sampling/detection clock enable |
| pin_in | input | 32 | Pin levels to monitor |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data (flag address: zero bits clear) |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Read data for rd_addr |
| irq_o | output | 4 | One request line per group of eight pins |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before it is released. This makes the previous-cycle values used by the sticky-flag and same-cycle-set checks the reset state. They also assume the pins change only between clock edges, so each edge samples one defined level. The bench drives every input at the falling edge. The only exception is the sub-cycle pulse, which is placed entirely inside the low half of the clock. The bench holds reset for several edges both at start-up and in the final re-reset scenario.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PIN_COUNT  = 32;
    localparam int GROUP_W    = 8;
    localparam int REG_AW     = 2;

    typedef enum logic [1:0] {
        TRIG_ANY     = 2'b00,
        TRIG_RISE    = 2'b01,
        TRIG_FALL    = 2'b10,
        TRIG_ANY_ALT = 2'b11
    } trig_e;

    typedef enum logic [REG_AW-1:0] {
        RA_ENABLE  = 2'd0,
        RA_MODE_LO = 2'd1,
        RA_MODE_HI = 2'd2,
        RA_FLAGS   = 2'd3
    } reg_addr_e;

    // One pin's two most recent samples
    typedef struct packed {
        logic cur;
        logic prv;
    } pin_pair_t;

    function automatic logic trig_match(input logic [1:0] mode, input pin_pair_t s);
        logic r;
        case (mode)
            TRIG_RISE: r = s.cur & ~s.prv;
            TRIG_FALL: r = ~s.cur & s.prv;
            default:   r = s.cur ^ s.prv;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int N = PIN_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    output logic [N-1:0]      en_o,
    output logic [2*N-1:0]    mode_o
);
    logic [N-1:0] en_q;
    logic [N-1:0] mode_lo_q;
    logic [N-1:0] mode_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            mode_lo_q <= '0;
            mode_hi_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_ENABLE:  en_q      <= wr_data;
                RA_MODE_LO: mode_lo_q <= wr_data;
                RA_MODE_HI: mode_hi_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign en_o   = en_q;
    assign mode_o = {mode_hi_q, mode_lo_q};
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det
    import gpio_irq_pkg::*;
#(
    parameter int N = PIN_COUNT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           smp_en,
    input  logic [N-1:0]   pin_i,
    input  logic [2*N-1:0] mode_i,
    output logic [N-1:0]   hit_o,
    output logic [N-1:0]   cur_o,
    output logic [N-1:0]   prv_o
);
    localparam int PRIME_W = 2;

    logic [N-1:0]       cur_q;
    logic [N-1:0]       prv_q;
    logic [PRIME_W-1:0] prime_q;
    logic               armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            prv_q   <= '0;
            prime_q <= '0;
        end else if (smp_en) begin
            cur_q   <= pin_i;
            prv_q   <= cur_q;
            prime_q <= {prime_q[PRIME_W-2:0], 1'b1};
        end
    end

    assign armed = prime_q[PRIME_W-1];

    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_pair_t pair;
        assign pair     = '{cur: cur_q[i], prv: prv_q[i]};
        assign hit_o[i] = armed & trig_match(mode_i[2*i +: 2], pair);
    end

    assign cur_o = cur_q;
    assign prv_o = prv_q;
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank
    import gpio_irq_pkg::*;
#(
    parameter int N = PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic [N-1:0] hit_i,
    input  logic         clr_we,
    input  logic [N-1:0] keep_mask,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;
    logic [N-1:0] kept;
    logic [N-1:0] setv;

    always_comb begin
        kept = clr_we ? (flag_q & keep_mask) : flag_q;
        setv = set_en ? hit_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= kept | setv;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or
    import gpio_irq_pkg::*;
#(
    parameter int N = PIN_COUNT,
    parameter int G = GROUP_W
) (
    input  logic [N-1:0]   flag_i,
    input  logic [N-1:0]   en_i,
    output logic [N/G-1:0] req_o
);
    localparam int NG = N / G;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign req_o[g] = |(flag_i[g*G +: G] & en_i[g*G +: G]);
    end
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = PIN_COUNT,
    parameter int GROUP_SIZE = GROUP_W,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clk_en,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     wr_addr,
    input  logic [NUM_PINS-1:0]   wr_data,
    input  logic [REG_AW-1:0]     rd_addr,
    output logic [NUM_PINS-1:0]   rd_data,
    output logic [NUM_GROUPS-1:0] irq_o
);
    logic [NUM_PINS-1:0]   en_q;
    logic [2*NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0]   hit_w;
    logic [NUM_PINS-1:0]   cur_w;
    logic [NUM_PINS-1:0]   prv_w;
    logic [NUM_PINS-1:0]   flag_q;
    logic                  flag_wr;

    assign flag_wr = wr_en && (reg_addr_e'(wr_addr) == RA_FLAGS);

    gpio_cfg_regs #(.N(NUM_PINS)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_o    (en_q),
        .mode_o  (mode_q)
    );

    gpio_edge_det #(.N(NUM_PINS)) u_det (
        .clk    (clk),
        .rst    (rst),
        .smp_en (clk_en),
        .pin_i  (pin_in),
        .mode_i (mode_q),
        .hit_o  (hit_w),
        .cur_o  (cur_w),
        .prv_o  (prv_w)
    );

    gpio_flag_bank #(.N(NUM_PINS)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_en    (clk_en),
        .hit_i     (hit_w),
        .clr_we    (flag_wr),
        .keep_mask (wr_data),
        .flag_o    (flag_q)
    );

    gpio_group_or #(.N(NUM_PINS), .G(GROUP_SIZE)) u_grp (
        .flag_i (flag_q),
        .en_i   (en_q),
        .req_o  (irq_o)
    );

    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_ENABLE:  rd_data = en_q;
            RA_MODE_LO: rd_data = mode_q[NUM_PINS-1:0];
            RA_MODE_HI: rd_data = mode_q[2*NUM_PINS-1:NUM_PINS];
            default:    rd_data = flag_q;
        endcase
    end
endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk #(
    parameter int N = 32,
    parameter int G = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         clk_en,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [N-1:0] flag,
    input logic [N-1:0] en,
    input logic [N-1:0] hit,
    input logic [N-1:0] cur,
    input logic [N-1:0] prv,
    input logic [N/G-1:0] irq
);
    // R8: without a flag write, no set flag is lost
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == 2'd3) |=> ((flag & $past(flag)) == $past(flag)));

    // R10: no flag rises while sampling is stopped
    a_r10_no_set_when_gated: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ((flag & ~$past(flag)) == '0));

    // R9: a detected event always lands, even against a clearing write
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> ((flag & $past(hit)) == $past(hit)));

    // R2/R13: a newly set flag needs two differing samples
    a_r13_new_flag_needs_change: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag & ~$past(flag) & ~($past(cur) ^ $past(prv))) == '0));

    // R7: no request lines without an enabled flag
    a_r7_quiet_without_flags: assert property (@(posedge clk) disable iff (rst)
        ((flag & en) == '0) |-> (irq == '0));

    // R1: reset leaves flags clear
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (flag == '0));
endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.N(NUM_PINS), .G(GROUP_SIZE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clk_en  (clk_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .flag    (flag_q),
    .en      (en_q),
    .hit     (hit_w),
    .cur     (cur_w),
    .prv     (prv_w),
    .irq     (irq_o)
);

// File: tb/gpio_chg_irq_test.sv
module gpio_chg_irq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic [31:0] pin_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_chg_irq uut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .pin_in(pin_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic expect_flags(input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(2'd3, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == '0, "R1", v, '0);
        end
        check(irq_o == '0, "R1", {28'd0, irq_o}, '0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd1, 32'h0000_00E4);
        wr(2'd2, 32'h0000_0100);
        wr(2'd0, 32'h0000_0000);
        rd(2'd1, v); check(v == 32'h0000_00E4, "R12", v, 32'h0000_00E4);
        rd(2'd2, v); check(v == 32'h0000_0100, "R12", v, 32'h0000_0100);
    endtask

    task automatic t_any();
        pin_in[0] = 1'b1;
        cyc(1);
        expect_flags('0, "R2 latency");
        cyc(1);
        expect_flags(32'h1, "R2 rise");
        wr(2'd3, '0);
        pin_in[0] = 1'b0;
        cyc(2);
        expect_flags(32'h1, "R2 fall");
        wr(2'd3, '0);
    endtask

    task automatic t_rise();
        pin_in[1] = 1'b1; pin_in[20] = 1'b1;
        cyc(2);
        expect_flags(32'h0010_0002, "R3 rise");
        wr(2'd3, '0);
        pin_in[1] = 1'b0; pin_in[20] = 1'b0;
        cyc(3);
        expect_flags('0, "R3 fall ignored");
    endtask

    task automatic t_fall();
        pin_in[2] = 1'b1;
        cyc(3);
        expect_flags('0, "R4 rise ignored");
        pin_in[2] = 1'b0;
        cyc(2);
        expect_flags(32'h4, "R4 fall");
        wr(2'd3, '0);
    endtask

    task automatic t_alt();
        pin_in[3] = 1'b1;
        cyc(2);
        expect_flags(32'h8, "R5 rise");
        wr(2'd3, '0);
        pin_in[3] = 1'b0;
        cyc(2);
        expect_flags(32'h8, "R5 fall");
        wr(2'd3, '0);
    endtask

    task automatic t_enable_groups();
        pin_in[9] = 1'b1; pin_in[30] = 1'b1;
        cyc(2);
        expect_flags(32'h4000_0200, "R6 flag without enable");
        check(irq_o == 4'b0000, "R6 no request", {28'd0, irq_o}, 32'h0);
        wr(2'd0, 32'h0000_0200);
        check(irq_o == 4'b0010, "R7 group1", {28'd0, irq_o}, 32'h2);
        wr(2'd0, 32'h4000_0200);
        check(irq_o == 4'b1010, "R7 groups1,3", {28'd0, irq_o}, 32'hA);
        wr(2'd3, ~32'h0000_0200);
        expect_flags(32'h4000_0000, "R8 masked clear");
        check(irq_o == 4'b1000, "R8 group1 drops", {28'd0, irq_o}, 32'h8);
        cyc(3);
        expect_flags(32'h4000_0000, "R8 sticky");
        wr(2'd3, '0);
        check(irq_o == 4'b0000, "R7 all low", {28'd0, irq_o}, 32'h0);
        pin_in[9] = 1'b0; pin_in[30] = 1'b0;
        cyc(2);
        wr(2'd3, '0);
        wr(2'd0, '0);
    endtask

    task automatic t_collide();
        pin_in[5] = 1'b1;
        cyc(1);
        wr(2'd3, '0);
        expect_flags(32'h20, "R9 set wins");
        wr(2'd3, '0);
    endtask

    task automatic t_gate();
        clk_en = 1'b0;
        pin_in[7] = 1'b1;
        cyc(4);
        expect_flags('0, "R10 gated");
        clk_en = 1'b1;
        cyc(2);
        expect_flags(32'h80, "R10 resumed");
        wr(2'd3, '0);
    endtask

    task automatic t_pulse();
        #1 pin_in[4] = 1'b1;
        #2 pin_in[4] = 1'b0;
        @(negedge clk);
        cyc(3);
        expect_flags('0, "R11 unsampled pulse");
        pin_in[4] = 1'b1;
        cyc(1);
        pin_in[4] = 1'b0;
        cyc(2);
        expect_flags(32'h10, "R11 sampled pulse");
        wr(2'd3, '0);
    endtask

    task automatic t_prime();
        pin_in[31] = 1'b1;
        do_reset();
        cyc(2);
        expect_flags('0, "R13 no start-up event");
    endtask

    initial begin
        rst = 1'b1;
        cyc(3);
        t_reset();
        rst = 1'b0;
        cyc(3);
        t_regs();
        t_any();
        t_rise();
        t_fall();
        t_alt();
        t_enable_groups();
        t_collide();
        t_gate();
        t_pulse();
        t_prime();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule